// File: doc/BRIEF.md
# Job Card Stream Loader

This block prepares a small word-addressed machine for a run. It takes a stream of job cards that have already been tokenised and, from them, builds the four segment origin words. It copies the object code and the initial workspace values into memory and hands over the starting program counter and the trace switch. Tokens arrive on a valid/ready port as a 3-bit kind plus a 32-bit value. Results leave through three outputs: a segment-register write port, a 32-bit memory write port and a one-cycle completion pulse. A token that does not fit the expected job order raises a one-cycle error pulse, and the loader then waits for a new job.

A job is a fixed sequence of tokens:

1. A job token.
2. Four segment lengths, in the order code, input, output, workspace.
3. Any number of object cards. Each card is a nibble count followed by that many nibbles.
4. A workspace count, followed by that many offset/value pairs.
5. A start token.

The segments are laid out end to end. The code segment starts at byte 0, and each later segment starts at the first byte after the one before it. Code nibbles are packed big-endian into 32-bit words and written one word at a time. The workspace count closes the code, and any partly filled last word is written with its unused low bits set to zero.

Top module: `card_loader`

## Requirements
- R1: After reset the loader is idle with tok_ready high, all pulse outputs low, start_pc zero and trace_on low.
- R2: The n-th segment length token of a job (kind 1, length in data[15:0]) produces, one cycle after it is accepted, a seg_we pulse with seg_sel = n (n counts 0 to 3). The accompanying seg_word has the base in bits 31:18 and the length in bits 17:0. Segment 0 always has base 0.
- R3: The base of segment n (n from 1 to 3) is the sum of the lengths of segments 0 through n-1, taken modulo 2^14.
- R4: Nibbles (kind 3, value in data[3:0]) are packed big-endian. The first nibble of a word goes to bits 31:28. Packing runs on across card boundaries. Word k of the code is written at byte address 4k, one cycle after its eighth nibble is accepted.
- R5: The workspace count token (kind 4) writes any partly filled code word, with its unused low bits zero. If the nibble total is a multiple of eight, no extra write occurs.
- R6: A nibble count token (kind 2, count in data[7:0]) makes the loader take exactly that many nibbles. A count of 0 is accepted and takes none.
- R7: After a workspace offset token (kind 5, data[15:0]) and a value token (kind 6, data[31:0]), the value is written at byte address (workspace base + 4 x offset) mod 2^14. The workspace count (data[15:0]) sets how many such pairs are taken.
- R8: A workspace count of 0 goes straight to waiting for the start token.
- R9: The start token (kind 7) loads start_pc from data[15:0] and gives a single-cycle load_done pulse. Both take effect one cycle after the token is accepted.
- R10: trace_on becomes 1 only when data[19:16] of the start token equals 1; any other value gives 0. It holds its value until the next start token.
- R11: A token of the wrong kind for the current step gives a one-cycle load_err pulse with no load_done and returns the loader to idle. In idle only kind 0 (job) is accepted. Any other kind there raises load_err again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Loader accepts a token (always high out of reset) |
| tok_kind | input | 3 | Token kind: 0 job, 1 length, 2 nibble count, 3 nibble, 4 workspace count, 5 offset, 6 value, 7 start |
| tok_data | input | 32 | Token value |
| seg_we | output | 1 | Segment origin write strobe |
| seg_sel | output | 2 | Segment origin register index |
| seg_word | output | 32 | Origin word {base[13:0], length[17:0]} |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 14 | Byte address of the write |
| mem_wdata | output | 32 | Write data |
| start_pc | output | 24 | Starting program counter |
| trace_on | output | 1 | Trace switch |
| load_done | output | 1 | Job loaded pulse |
| load_err | output | 1 | Token order error pulse |

## Verification
The bench builds the loader with its default parameters: 32-bit words packed big-endian, a 14-bit byte address and 16-bit length fields. With a 32-bit word, eight nibbles fill one word, so short cards are enough to reach word completion across a card boundary, the zero-padded flush and the no-flush case. With a 14-bit base field, lengths of a few thousand bytes are enough to make the running base wrap to zero.

// File: rtl/cardld_pkg.sv
`timescale 1ns/1ps
package cardld_pkg;

   typedef enum logic [2:0] {
      TK_JOB     = 3'd0,
      TK_SEGLEN  = 3'd1,
      TK_NIBCNT  = 3'd2,
      TK_NIBBLE  = 3'd3,
      TK_WSCOUNT = 3'd4,
      TK_WSOFF   = 3'd5,
      TK_WSVAL   = 3'd6,
      TK_START   = 3'd7
   } tok_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEN   = 3'd1,
      ST_OBJ   = 3'd2,
      ST_NIB   = 3'd3,
      ST_WSOFF = 3'd4,
      ST_WSVAL = 3'd5,
      ST_START = 3'd6
   } ld_state_e;

endpackage

// File: rtl/cardld_seg_alloc.sv
`timescale 1ns/1ps
module cardld_seg_alloc #(
   parameter int BASE_W = 14,
   parameter int SLEN_W = 18,
   parameter int LEN_W  = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              len_valid,
   input  logic [1:0]        len_sel,
   input  logic [LEN_W-1:0]  len_val,
   output logic              seg_we,
   output logic [1:0]        seg_sel,
   output logic [WORD_W-1:0] seg_word,
   output logic [BASE_W-1:0] ws_base
);

   if (BASE_W + SLEN_W != WORD_W) begin : g_bad_split
      $error("cardld_seg_alloc: base and length fields must fill the word");
   end
   if (LEN_W > SLEN_W) begin : g_bad_len
      $error("cardld_seg_alloc: length token wider than length field");
   end

   logic [BASE_W-1:0] next_free;
   logic [BASE_W-1:0] len_trunc;

   assign len_trunc = BASE_W'(len_val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_free <= '0;
         seg_we    <= 1'b0;
         seg_sel   <= '0;
         seg_word  <= '0;
         ws_base   <= '0;
      end else begin
         seg_we <= 1'b0;
         if (clear) begin
            next_free <= '0;
         end else if (len_valid) begin
            seg_we    <= 1'b1;
            seg_sel   <= len_sel;
            seg_word  <= {next_free, SLEN_W'(len_val)};
            next_free <= next_free + len_trunc;
            if (len_sel == 2'd3) ws_base <= next_free;
         end
      end
   end

   // checker: end of the previously announced segment
   logic [BASE_W-1:0] chk_end;
   always_ff @(posedge clk) begin
      if (!rst_n || clear) chk_end <= '0;
      else if (seg_we)     chk_end <= seg_word[WORD_W-1 -: BASE_W] + BASE_W'(seg_word[SLEN_W-1:0]);
   end

   AST_BASE0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_we && seg_sel == 2'd0) |-> seg_word[WORD_W-1 -: BASE_W] == '0); // R2
   AST_BASE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      seg_we |-> seg_word[WORD_W-1 -: BASE_W] == chk_end); // R3

endmodule

// File: rtl/cardld_code_pack.sv
`timescale 1ns/1ps
module cardld_code_pack #(
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 14,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              nib_valid,
   input  logic [3:0]        nib,
   input  logic              flush,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data
);

   localparam int NPW    = WORD_W / 4;
   localparam int POS_W  = $clog2(NPW);
   localparam int SH_W   = $clog2(WORD_W);
   localparam int WIDX_W = ADDR_W - 2;

   if ((1 << SH_W) != WORD_W || WORD_W < 16) begin : g_bad_word
      $error("cardld_code_pack: word width must be a power of two of at least 16");
   end

   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] acc_ins;
   logic [POS_W-1:0]  pos;
   logic [WIDX_W-1:0] widx;
   logic [SH_W-1:0]   nib_shift;
   logic              last_nib;

   if (BIG_ENDIAN) begin : g_big
      always_comb nib_shift = SH_W'(WORD_W - 4) - {pos, 2'b00};
   end else begin : g_little
      always_comb nib_shift = {pos[POS_W-1:1], 3'b000} + (pos[0] ? SH_W'(0) : SH_W'(4));
   end

   assign acc_ins  = acc | (WORD_W'(nib) << nib_shift);
   assign last_nib = (pos == POS_W'(NPW - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc      <= '0;
         pos      <= '0;
         widx     <= '0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= 1'b0;
         if (clear) begin
            acc  <= '0;
            pos  <= '0;
            widx <= '0;
         end else if (nib_valid) begin
            if (last_nib) begin
               wr_valid <= 1'b1;
               wr_data  <= acc_ins;
               wr_addr  <= {widx, 2'b00};
               widx     <= widx + 1'b1;
               acc      <= '0;
               pos      <= '0;
            end else begin
               acc <= acc_ins;
               pos <= pos + 1'b1;
            end
         end else if (flush && pos != '0) begin
            wr_valid <= 1'b1;
            wr_data  <= acc;
            wr_addr  <= {widx, 2'b00};
            widx     <= widx + 1'b1;
            acc      <= '0;
            pos      <= '0;
         end
      end
   end

   // checker: code words land at consecutive word addresses
   logic [ADDR_W-1:0] chk_next;
   always_ff @(posedge clk) begin
      if (!rst_n || clear) chk_next <= '0;
      else if (wr_valid)   chk_next <= wr_addr + ADDR_W'(4);
   end

   AST_CODE_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_addr == chk_next); // R4
   AST_NO_EMPTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !nib_valid && pos == '0) |=> !wr_valid); // R5

endmodule

// File: rtl/cardld_ws_init.sv
`timescale 1ns/1ps
module cardld_ws_init #(
   parameter int ADDR_W = 14,
   parameter int CNT_W  = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              off_valid,
   input  logic [CNT_W-1:0]  off,
   input  logic              val_valid,
   input  logic [WORD_W-1:0] val,
   input  logic [ADDR_W-1:0] base,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data
);

   logic [CNT_W-1:0]  off_q;
   logic [ADDR_W-1:0] off_bytes;

   assign off_bytes = ADDR_W'({off_q, 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q    <= '0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= 1'b0;
         if (off_valid) off_q <= off;
         if (val_valid) begin
            wr_valid <= 1'b1;
            wr_addr  <= base + off_bytes;
            wr_data  <= val;
         end
      end
   end

   AST_WS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(val_valid)); // R7

endmodule

// File: rtl/card_loader.sv
`timescale 1ns/1ps
module card_loader
   import cardld_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 14,
   parameter int SLEN_W     = 18,
   parameter int LEN_W      = 16,
   parameter int NIBCNT_W   = 8,
   parameter int CNT_W      = 16,
   parameter int START_W    = 16,
   parameter int PC_W       = 24,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   output logic              tok_ready,
   input  logic [2:0]        tok_kind,
   input  logic [WORD_W-1:0] tok_data,
   output logic              seg_we,
   output logic [1:0]        seg_sel,
   output logic [WORD_W-1:0] seg_word,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [PC_W-1:0]   start_pc,
   output logic              trace_on,
   output logic              load_done,
   output logic              load_err
);

   localparam int TRACE_LO = START_W;

   if (START_W + 4 > WORD_W) begin : g_bad_start
      $error("card_loader: start field and trace field exceed token width");
   end
   if (PC_W < START_W) begin : g_bad_pc
      $error("card_loader: program counter narrower than start field");
   end
   if (CNT_W > WORD_W || NIBCNT_W > WORD_W || LEN_W > WORD_W) begin : g_bad_cnt
      $error("card_loader: count fields exceed token width");
   end

   tok_kind_e kind;
   ld_state_e state, state_nxt;

   logic [1:0]          len_idx;
   logic [NIBCNT_W-1:0] nib_left;
   logic [CNT_W-1:0]    ws_left;

   logic clear_s, seg_s, nibcnt_s, nib_s, flush_s, off_s, val_s, fin_s, bad_s;

   assign kind      = tok_kind_e'(tok_kind);
   assign tok_ready = 1'b1;

   always_comb begin
      state_nxt = state;
      clear_s   = 1'b0;
      seg_s     = 1'b0;
      nibcnt_s  = 1'b0;
      nib_s     = 1'b0;
      flush_s   = 1'b0;
      off_s     = 1'b0;
      val_s     = 1'b0;
      fin_s     = 1'b0;
      bad_s     = 1'b0;
      if (tok_valid) begin
         case (state)
            ST_IDLE: begin
               if (kind == TK_JOB) begin
                  clear_s   = 1'b1;
                  state_nxt = ST_LEN;
               end else bad_s = 1'b1;
            end
            ST_LEN: begin
               if (kind == TK_SEGLEN) begin
                  seg_s = 1'b1;
                  if (len_idx == 2'd3) state_nxt = ST_OBJ;
               end else bad_s = 1'b1;
            end
            ST_OBJ: begin
               if (kind == TK_NIBCNT) begin
                  nibcnt_s = 1'b1;
                  if (tok_data[NIBCNT_W-1:0] != '0) state_nxt = ST_NIB;
               end else if (kind == TK_WSCOUNT) begin
                  flush_s   = 1'b1;
                  state_nxt = (tok_data[CNT_W-1:0] == '0) ? ST_START : ST_WSOFF;
               end else bad_s = 1'b1;
            end
            ST_NIB: begin
               if (kind == TK_NIBBLE) begin
                  nib_s = 1'b1;
                  if (nib_left == NIBCNT_W'(1)) state_nxt = ST_OBJ;
               end else bad_s = 1'b1;
            end
            ST_WSOFF: begin
               if (kind == TK_WSOFF) begin
                  off_s     = 1'b1;
                  state_nxt = ST_WSVAL;
               end else bad_s = 1'b1;
            end
            ST_WSVAL: begin
               if (kind == TK_WSVAL) begin
                  val_s     = 1'b1;
                  state_nxt = (ws_left == CNT_W'(1)) ? ST_START : ST_WSOFF;
               end else bad_s = 1'b1;
            end
            ST_START: begin
               if (kind == TK_START) begin
                  fin_s     = 1'b1;
                  state_nxt = ST_IDLE;
               end else bad_s = 1'b1;
            end
            default: bad_s = 1'b1;
         endcase
         if (bad_s) state_nxt = ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         len_idx   <= '0;
         nib_left  <= '0;
         ws_left   <= '0;
         start_pc  <= '0;
         trace_on  <= 1'b0;
         load_done <= 1'b0;
         load_err  <= 1'b0;
      end else begin
         state     <= state_nxt;
         load_done <= fin_s;
         load_err  <= bad_s;
         if (clear_s)    len_idx  <= '0;
         else if (seg_s) len_idx  <= len_idx + 1'b1;
         if (nibcnt_s)   nib_left <= tok_data[NIBCNT_W-1:0];
         else if (nib_s) nib_left <= nib_left - 1'b1;
         if (flush_s)    ws_left  <= tok_data[CNT_W-1:0];
         else if (val_s) ws_left  <= ws_left - 1'b1;
         if (fin_s) begin
            start_pc <= PC_W'(tok_data[START_W-1:0]);
            trace_on <= (tok_data[TRACE_LO +: 4] == 4'd1);
         end
      end
   end

   logic [ADDR_W-1:0] ws_base;
   logic              pk_wv, ws_wv;
   logic [ADDR_W-1:0] pk_addr, ws_addr;
   logic [WORD_W-1:0] pk_data, ws_data;

   cardld_seg_alloc #(
      .BASE_W (ADDR_W),
      .SLEN_W (SLEN_W),
      .LEN_W  (LEN_W),
      .WORD_W (WORD_W)
   ) u_seg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_s),
      .len_valid (seg_s),
      .len_sel   (len_idx),
      .len_val   (tok_data[LEN_W-1:0]),
      .seg_we    (seg_we),
      .seg_sel   (seg_sel),
      .seg_word  (seg_word),
      .ws_base   (ws_base)
   );

   cardld_code_pack #(
      .WORD_W     (WORD_W),
      .ADDR_W     (ADDR_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear_s),
      .nib_valid (nib_s),
      .nib       (tok_data[3:0]),
      .flush     (flush_s),
      .wr_valid  (pk_wv),
      .wr_addr   (pk_addr),
      .wr_data   (pk_data)
   );

   cardld_ws_init #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .WORD_W (WORD_W)
   ) u_ws (
      .clk       (clk),
      .rst_n     (rst_n),
      .off_valid (off_s),
      .off       (tok_data[CNT_W-1:0]),
      .val_valid (val_s),
      .val       (tok_data),
      .base      (ws_base),
      .wr_valid  (ws_wv),
      .wr_addr   (ws_addr),
      .wr_data   (ws_data)
   );

   assign mem_we    = pk_wv | ws_wv;
   assign mem_addr  = pk_wv ? pk_addr : ws_addr;
   assign mem_wdata = pk_wv ? pk_data : ws_data;

   AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pk_wv, ws_wv})); // R7
   AST_NIB_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NIB) |-> nib_left != '0); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> !load_done); // R9
   AST_TRACE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_on != $past(trace_on)) |-> load_done); // R10
   AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> (state == ST_IDLE && !load_done)); // R11

endmodule

// File: tb/card_loader_tb.sv
`timescale 1ns/1ps
module card_loader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tok_valid = 1'b0;
   logic        tok_ready;
   logic [2:0]  tok_kind = 3'd0;
   logic [31:0] tok_data = '0;
   logic        seg_we;
   logic [1:0]  seg_sel;
   logic [31:0] seg_word;
   logic        mem_we;
   logic [13:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [23:0] start_pc;
   logic        trace_on;
   logic        load_done;
   logic        load_err;

   always #4 clk = ~clk;

   card_loader u_dut (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
      .tok_kind(tok_kind), .tok_data(tok_data), .seg_we(seg_we), .seg_sel(seg_sel),
      .seg_word(seg_word), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .start_pc(start_pc), .trace_on(trace_on), .load_done(load_done), .load_err(load_err)
   );

   int errs = 0;
   int checks = 0;

   logic [31:0] seg_log [4];
   logic [13:0] ma [64];
   logic [31:0] md [64];
   int seg_cnt, mem_cnt, done_cnt, err_cnt;

   always @(negedge clk) begin
      if (rst_n) begin
         if (seg_we) begin
            seg_log[seg_sel] = seg_word;
            seg_cnt++;
         end
         if (mem_we && mem_cnt < 64) begin
            ma[mem_cnt] = mem_addr;
            md[mem_cnt] = mem_wdata;
            mem_cnt++;
         end
         if (load_done) done_cnt++;
         if (load_err)  err_cnt++;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      seg_cnt = 0; mem_cnt = 0; done_cnt = 0; err_cnt = 0;
      for (int i = 0; i < 4; i++) seg_log[i] = '0;
   endtask

   task automatic send(logic [2:0] k, logic [31:0] d);
      tok_kind  = k;
      tok_data  = d;
      tok_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic settle();
      tok_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] seg_exp(int unsigned base, int unsigned len);
      return {base[13:0], 2'b00, len[15:0]};
   endfunction

   task automatic t_reset();
      chk("R1", "tok_ready", tok_ready, 1);
      chk("R1", "pulses", {seg_we, mem_we, load_done, load_err}, 0);
      chk("R1", "start_pc/trace", {start_pc, trace_on}, 0);
   endtask

   task automatic t_basic();
      int unsigned l[4] = '{32'h000A, 32'h0008, 32'h0006, 32'h0010};
      int unsigned b3;
      clear_logs();
      send(3'd0, 0);
      for (int i = 0; i < 4; i++) send(3'd1, l[i]);
      send(3'd2, 6);
      for (int i = 1; i <= 6; i++) send(3'd3, i);
      send(3'd2, 0);
      send(3'd2, 5);
      for (int i = 7; i <= 11; i++) send(3'd3, i);
      send(3'd4, 2);
      send(3'd5, 1);  send(3'd6, 32'hDEADBEEF);
      send(3'd5, 3);  send(3'd6, 32'h12345678);
      send(3'd7, 32'h0001_0004);
      settle();
      b3 = l[0] + l[1] + l[2];
      chk("R2", "seg count", seg_cnt, 4);
      chk("R2", "seg0 word", seg_log[0], seg_exp(0, l[0]));
      chk("R3", "seg1 word", seg_log[1], seg_exp(l[0], l[1]));
      chk("R3", "seg2 word", seg_log[2], seg_exp(l[0] + l[1], l[2]));
      chk("R3", "seg3 word", seg_log[3], seg_exp(b3, l[3]));
      chk("R6", "mem writes", mem_cnt, 4);
      chk("R4", "word0", {ma[0], md[0]}, {14'd0, 32'h12345678});
      chk("R5", "padded word1", {ma[1], md[1]}, {14'd4, 32'h9AB00000});
      chk("R7", "ws write a", {ma[2], md[2]}, {14'(b3 + 4), 32'hDEADBEEF});
      chk("R7", "ws write b", {ma[3], md[3]}, {14'(b3 + 12), 32'h12345678});
      chk("R9", "done count", done_cnt, 1);
      chk("R9", "start_pc", start_pc, 24'h4);
      chk("R10", "trace for 1", trace_on, 1);
      chk("R11", "no error", err_cnt, 0);
   endtask

   task automatic t_aligned_wrap();
      int unsigned l[4] = '{32'h3000, 32'h1000, 32'h0004, 32'h0008};
      clear_logs();
      send(3'd0, 0);
      for (int i = 0; i < 4; i++) send(3'd1, l[i]);
      send(3'd2, 8);
      for (int i = 0; i < 8; i++) send(3'd3, i);
      send(3'd4, 0);
      send(3'd7, 32'h0002_FFFF);
      settle();
      chk("R3", "seg1 wrap word", seg_log[1], seg_exp(l[0], l[1]));
      chk("R3", "seg2 base wraps to 0", seg_log[2], seg_exp(0, l[2]));
      chk("R3", "seg3 word", seg_log[3], seg_exp(4, l[3]));
      chk("R5", "no flush when aligned", mem_cnt, 1);
      chk("R4", "full word", {ma[0], md[0]}, {14'd0, 32'h01234567});
      chk("R8", "zero ws count finishes", done_cnt, 1);
      chk("R9", "start_pc ffff", start_pc, 24'hFFFF);
      chk("R10", "trace off for 2", trace_on, 0);
   endtask

   task automatic t_errors();
      clear_logs();
      send(3'd0, 0);
      send(3'd1, 4);
      send(3'd3, 5);
      settle();
      chk("R11", "bad token err", err_cnt, 1);
      chk("R11", "no done on err", done_cnt, 0);
      chk("R11", "no write on err", mem_cnt, 0);
      clear_logs();
      send(3'd6, 32'h55);
      settle();
      chk("R11", "idle rejects non-job", err_cnt, 1);
      clear_logs();
      send(3'd0, 0);
      for (int i = 0; i < 4; i++) send(3'd1, 4);
      send(3'd2, 2);
      send(3'd2, 1);
      settle();
      chk("R6", "count card inside nibbles is error", err_cnt, 1);
      clear_logs();
      send(3'd0, 0);
      for (int i = 0; i < 4; i++) send(3'd1, 4);
      send(3'd4, 0);
      send(3'd7, 32'h0001_0020);
      settle();
      chk("R11", "restart after error", {err_cnt, done_cnt}, {32'd0, 32'd1});
      chk("R2", "restart seg3", seg_log[3], seg_exp(12, 4));
      chk("R5", "no code no write", mem_cnt, 0);
      chk("R10", "trace on again", {start_pc, trace_on}, {24'h20, 1'b1});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      clear_logs();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_aligned_wrap();
      t_errors();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule